// File: doc/BRIEF.md
# ADC Indexed Channel Sequencer

This block steers the input multiplexer of a converter across a fixed table of sixteen indexed slots. Index 0 selects the offset node, 1 and 2 the two external inputs, 3 the temperature node, 4 through 8 five self-diagnostic nodes, and 9 through 15 ground. Software picks a window of indices with a first and a last field and starts work by writing the trigger bit. In one-shot mode the window is converted once. In looping mode it wraps from the last index back to the first until software writes the trigger bit to 0. The block derives a conversion clock from the system clock. For each slot it pulses a convert-start strobe with the index on the mux select. It captures the converter's done data, and at the end of the slot it writes that data to a per-index result register.

Every slot lasts a whole number of conversion-clock periods. Internal nodes use the 20-period minimum. Each external input can add a programmed number of idle periods to lengthen its slot. External input 1 can be disabled as a converter input. Its slot is then still spent in full, but its result is stored as zero. A range bit for the external inputs can only be set while a supply-high indicator is asserted. All configuration is frozen while the sequencer is busy.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, busy and the trigger bit are 0, the first index reads 0, the last index reads 8, looping mode and the range bit are 0, mux_sel is 0, the external input 1 enable is 1, both rate codes are 0, and every result register reads 0.
- R2: The conversion clock is the system clock divided by 16, and it restarts with each slot. A slot lasts (20 + 4*code) conversion-clock periods. The code is rate_ext0 for index 1, rate_ext1 for index 2, and 0 for every other index. The next convert-start strobe, or the fall of busy, therefore comes exactly 16 times that many system cycles after the strobe.
- R3: A trigger write of 1 while idle starts a sequence. From the next cycle, busy and trig_bit are 1. Each slot begins with a one-cycle conv_start pulse, with mux_sel holding the slot index for the whole slot. Indices run in ascending order from the first index to the last index. In one-shot mode (cfg_loop=0), busy and trig_bit fall together at the end of the last slot.
- R4: When first equals last, only that index is converted. When first exceeds last, the window collapses to the single index given by the last field.
- R5: In looping mode (cfg_loop=1), the slot after the last index is the first index again, for as long as the trigger bit stays 1.
- R6: A trigger write of 0 during a sequence clears trig_bit on the next cycle. The slot in progress completes and stores its result, busy falls at that slot's end, and no further conv_start is issued.
- R7: At the end of each slot, the result register of the slot index takes the data of the latest conv_done seen during the slot, or 0 if none was seen. In the following cycle res_valid is high for exactly one cycle, with res_idx and res_data showing that index and value. rd_data returns the register selected by rd_idx.
- R8: With cfg_ext1_en=0, index 2 still takes its full slot time, and its stored and reported result is 0.
- R9: A configuration write sets the range bit only if supply_hi is 1 in that cycle. Otherwise the range bit is written as 0.
- R10: Configuration writes while busy is 1 are ignored. A trigger write of 1 while busy has no effect.
- R11: busy is high from the cycle after an accepted trigger until the end of the final slot, or of the slot in flight at a stop request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_first | input | 4 | First index of the window |
| cfg_last | input | 4 | Last index of the window |
| cfg_loop | input | 1 | 1 = looping mode, 0 = one-shot mode |
| cfg_range_hi | input | 1 | Requested wide-range bit for the external inputs |
| cfg_ext1_en | input | 1 | External input 1 enabled as a converter input |
| cfg_rate_ext0 | input | 2 | Rate code for index 1 |
| cfg_rate_ext1 | input | 2 | Rate code for index 2 |
| supply_hi | input | 1 | Supply-high indicator gating the range bit |
| trig_wr | input | 1 | Trigger bit write strobe |
| trig_val | input | 1 | Value written to the trigger bit |
| conv_done | input | 1 | Converter result valid |
| conv_data | input | 12 | Converter result |
| rd_idx | input | 4 | Result register select |
| trig_bit | output | 1 | Trigger bit readback |
| busy | output | 1 | Sequence in progress |
| mux_sel | output | 4 | Index driving the input multiplexer |
| conv_start | output | 1 | One-cycle convert-start strobe |
| res_valid | output | 1 | One-cycle stored-result pulse |
| res_idx | output | 4 | Index of the stored result |
| res_data | output | 12 | Value of the stored result |
| rd_data | output | 12 | Selected result register |
| first_rb | output | 4 | First index readback |
| last_rb | output | 4 | Last index readback |
| loop_rb | output | 1 | Mode readback |
| range_rb | output | 1 | Range bit readback |

## Verification
A wrong slot counter or divider phase shows up in the very next conv_start or busy fall. That edge lands a multiple of 16 cycles away from its expected place, so the error is visible within one slot. A wrong index or window clamp shows on mux_sel in the cycle the slot starts. A wrong latch or ext1 gate shows on res_data in the cycle after the slot ends, and stays readable on rd_data. A mishandled stop request appears as an extra strobe, or as busy staying high one slot too long.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   localparam int unsigned NUM_SLOTS = 16;
   localparam int unsigned IDX_W     = $clog2(NUM_SLOTS);
   localparam int unsigned RATE_W    = 2;

   typedef logic [IDX_W-1:0] slot_idx_t;

   // fixed positions in the slot table that change behaviour
   localparam slot_idx_t SLOT_EXT0 = slot_idx_t'(1);
   localparam slot_idx_t SLOT_EXT1 = slot_idx_t'(2);

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_t;

   typedef struct packed {
      slot_idx_t         first;
      slot_idx_t         last;
      logic              loop_en;
      logic              range_hi;
      logic              ext1_en;
      logic [RATE_W-1:0] rate_ext0;
      logic [RATE_W-1:0] rate_ext1;
   } seq_cfg_t;

endpackage

// File: rtl/adc_seq_clkdiv.sv
module adc_seq_clkdiv #(
   parameter int unsigned DIV = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);
   localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

   if (DIV < 2) begin : g_bad_div
      $error("adc_seq_clkdiv: DIV must be at least 2");
   end

   logic [CW-1:0] phase_q;

   assign tick = (phase_q == CW'(DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (restart || tick) begin
         phase_q <= '0;
      end else begin
         phase_q <= phase_q + 1'b1;
      end
   end

endmodule

// File: rtl/adc_seq_cfg.sv
module adc_seq_cfg
   import adc_seq_pkg::*;
#(
   parameter int unsigned FIRST_RST = 0,
   parameter int unsigned LAST_RST  = 8
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wr_en,
   input  logic      busy,
   input  logic      supply_hi,
   input  seq_cfg_t  wr_cfg,
   output seq_cfg_t  cfg_q,
   output slot_idx_t win_lo,
   output slot_idx_t win_hi
);

   if (FIRST_RST >= NUM_SLOTS || LAST_RST >= NUM_SLOTS) begin : g_bad_rst
      $error("adc_seq_cfg: reset indices must address the slot table");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q.first     <= slot_idx_t'(FIRST_RST);
         cfg_q.last      <= slot_idx_t'(LAST_RST);
         cfg_q.loop_en   <= 1'b0;
         cfg_q.range_hi  <= 1'b0;
         cfg_q.ext1_en   <= 1'b1;
         cfg_q.rate_ext0 <= '0;
         cfg_q.rate_ext1 <= '0;
      end else if (wr_en && !busy) begin
         cfg_q          <= wr_cfg;
         cfg_q.range_hi <= wr_cfg.range_hi & supply_hi;
      end
   end

   // a first index above the last one collapses onto the last one
   assign win_hi = cfg_q.last;
   assign win_lo = (cfg_q.first > cfg_q.last) ? cfg_q.last : cfg_q.first;

endmodule

// File: rtl/adc_seq_results.sv
module adc_seq_results
   import adc_seq_pkg::*;
#(
   parameter int unsigned DW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  slot_idx_t     wr_idx,
   input  logic [DW-1:0] wr_data,
   input  slot_idx_t     rd_idx,
   output logic [DW-1:0] rd_data
);

   if (NUM_SLOTS != (1 << IDX_W)) begin : g_bad_depth
      $error("adc_seq_results: slot count must be a power of two");
   end

   logic [DW-1:0] bank [NUM_SLOTS];

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_entry
      logic [DW-1:0] entry_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            entry_q <= '0;
         end else if (wr_en && (wr_idx == slot_idx_t'(g))) begin
            entry_q <= wr_data;
         end
      end
      assign bank[g] = entry_q;
   end

   assign rd_data = bank[rd_idx];

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
   import adc_seq_pkg::*;
#(
   parameter int unsigned MIN_TICKS = 20,
   parameter int unsigned RATE_STEP = 4,
   parameter int unsigned DW        = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  slot_idx_t         win_lo,
   input  slot_idx_t         win_hi,
   input  logic              loop_en,
   input  logic              ext1_en,
   input  logic [RATE_W-1:0] rate_ext0,
   input  logic [RATE_W-1:0] rate_ext1,
   input  logic              trig_wr,
   input  logic              trig_val,
   input  logic              conv_done,
   input  logic [DW-1:0]     conv_data,
   output logic              busy,
   output logic              trig_bit,
   output logic              conv_start,
   output logic              restart,
   output slot_idx_t         cur_idx,
   output logic              store_en,
   output logic [DW-1:0]     store_data,
   output logic              res_valid,
   output slot_idx_t         res_idx,
   output logic [DW-1:0]     res_data
);
   localparam int unsigned MAX_TICKS = MIN_TICKS + RATE_STEP * ((1 << RATE_W) - 1);
   localparam int unsigned CNT_W     = (MAX_TICKS > 1) ? $clog2(MAX_TICKS) : 1;

   if (MIN_TICKS < 1) begin : g_bad_min
      $error("adc_seq_fsm: MIN_TICKS must be at least 1");
   end

   seq_state_t    state_q;
   logic          trig_q;
   slot_idx_t     cur_q;
   logic [CNT_W-1:0] tcnt_q;
   logic [CNT_W-1:0] len_m1;
   logic [DW-1:0] lat_q;
   logic          start_q;
   logic          rv_q;
   slot_idx_t     ridx_q;
   logic [DW-1:0] rdat_q;

   logic          slot_end;
   logic          accept;
   logic          launch;
   logic          finish;
   logic          oneshot_done;
   slot_idx_t     nxt_idx;

   assign busy = (state_q == SEQ_RUN);

   // slot length in conversion-clock periods, minus one
   always_comb begin
      unique case (cur_q)
         SLOT_EXT0: len_m1 = CNT_W'(MIN_TICKS - 1) + CNT_W'(RATE_STEP) * CNT_W'(rate_ext0);
         SLOT_EXT1: len_m1 = CNT_W'(MIN_TICKS - 1) + CNT_W'(RATE_STEP) * CNT_W'(rate_ext1);
         default:   len_m1 = CNT_W'(MIN_TICKS - 1);
      endcase
   end

   assign slot_end     = busy && tick && (tcnt_q == len_m1);
   assign accept       = trig_wr && trig_val && !busy;
   assign oneshot_done = slot_end && trig_q && (cur_q == win_hi) && !loop_en;

   always_comb begin
      launch  = 1'b0;
      finish  = 1'b0;
      nxt_idx = cur_q;
      if (accept) begin
         launch  = 1'b1;
         nxt_idx = win_lo;
      end else if (slot_end) begin
         if (!trig_q) begin
            finish = 1'b1;
         end else if (cur_q == win_hi) begin
            if (loop_en) begin
               launch  = 1'b1;
               nxt_idx = win_lo;
            end else begin
               finish = 1'b1;
            end
         end else begin
            launch  = 1'b1;
            nxt_idx = cur_q + 1'b1;
         end
      end
   end

   assign store_en   = slot_end;
   assign store_data = ((cur_q == SLOT_EXT1) && !ext1_en) ? '0 : lat_q;
   assign restart    = launch || !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         trig_q  <= 1'b0;
         cur_q   <= '0;
         tcnt_q  <= '0;
         lat_q   <= '0;
         start_q <= 1'b0;
      end else begin
         if (launch) begin
            state_q <= SEQ_RUN;
         end else if (finish) begin
            state_q <= SEQ_IDLE;
         end

         if (trig_wr && !trig_val) begin
            trig_q <= 1'b0;
         end else if (accept) begin
            trig_q <= 1'b1;
         end else if (oneshot_done) begin
            trig_q <= 1'b0;
         end

         cur_q   <= nxt_idx;
         start_q <= launch;

         if (launch) begin
            tcnt_q <= '0;
         end else if (busy && tick) begin
            tcnt_q <= tcnt_q + 1'b1;
         end

         if (launch) begin
            lat_q <= '0;
         end else if (busy && conv_done) begin
            lat_q <= conv_data;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rv_q   <= 1'b0;
         ridx_q <= '0;
         rdat_q <= '0;
      end else begin
         rv_q <= slot_end;
         if (slot_end) begin
            ridx_q <= cur_q;
            rdat_q <= store_data;
         end
      end
   end

   assign trig_bit   = trig_q;
   assign conv_start = start_q;
   assign cur_idx    = cur_q;
   assign res_valid  = rv_q;
   assign res_idx    = ridx_q;
   assign res_data   = rdat_q;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int unsigned RES_W     = 12,
   parameter int unsigned CLK_DIV   = 16,
   parameter int unsigned MIN_TICKS = 20,
   parameter int unsigned RATE_STEP = 4,
   parameter int unsigned FIRST_RST = 0,
   parameter int unsigned LAST_RST  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [IDX_W-1:0]  cfg_first,
   input  logic [IDX_W-1:0]  cfg_last,
   input  logic              cfg_loop,
   input  logic              cfg_range_hi,
   input  logic              cfg_ext1_en,
   input  logic [RATE_W-1:0] cfg_rate_ext0,
   input  logic [RATE_W-1:0] cfg_rate_ext1,
   input  logic              supply_hi,
   input  logic              trig_wr,
   input  logic              trig_val,
   input  logic              conv_done,
   input  logic [RES_W-1:0]  conv_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              trig_bit,
   output logic              busy,
   output logic [IDX_W-1:0]  mux_sel,
   output logic              conv_start,
   output logic              res_valid,
   output logic [IDX_W-1:0]  res_idx,
   output logic [RES_W-1:0]  res_data,
   output logic [RES_W-1:0]  rd_data,
   output logic [IDX_W-1:0]  first_rb,
   output logic [IDX_W-1:0]  last_rb,
   output logic              loop_rb,
   output logic              range_rb
);

   if (RES_W < 1) begin : g_bad_width
      $error("adc_seq_ctrl: RES_W must be at least 1");
   end

   seq_cfg_t      wr_cfg;
   seq_cfg_t      cfg_q;
   slot_idx_t     win_lo;
   slot_idx_t     win_hi;
   logic          tick;
   logic          restart;
   logic          store_en;
   slot_idx_t     cur_idx;
   logic [RES_W-1:0] store_data;

   assign wr_cfg = '{first:     cfg_first,
                     last:      cfg_last,
                     loop_en:   cfg_loop,
                     range_hi:  cfg_range_hi,
                     ext1_en:   cfg_ext1_en,
                     rate_ext0: cfg_rate_ext0,
                     rate_ext1: cfg_rate_ext1};

   adc_seq_cfg #(
      .FIRST_RST (FIRST_RST),
      .LAST_RST  (LAST_RST)
   ) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_wr),
      .busy      (busy),
      .supply_hi (supply_hi),
      .wr_cfg    (wr_cfg),
      .cfg_q     (cfg_q),
      .win_lo    (win_lo),
      .win_hi    (win_hi)
   );

   adc_seq_clkdiv #(
      .DIV (CLK_DIV)
   ) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .tick    (tick)
   );

   adc_seq_fsm #(
      .MIN_TICKS (MIN_TICKS),
      .RATE_STEP (RATE_STEP),
      .DW        (RES_W)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .win_lo     (win_lo),
      .win_hi     (win_hi),
      .loop_en    (cfg_q.loop_en),
      .ext1_en    (cfg_q.ext1_en),
      .rate_ext0  (cfg_q.rate_ext0),
      .rate_ext1  (cfg_q.rate_ext1),
      .trig_wr    (trig_wr),
      .trig_val   (trig_val),
      .conv_done  (conv_done),
      .conv_data  (conv_data),
      .busy       (busy),
      .trig_bit   (trig_bit),
      .conv_start (conv_start),
      .restart    (restart),
      .cur_idx    (cur_idx),
      .store_en   (store_en),
      .store_data (store_data),
      .res_valid  (res_valid),
      .res_idx    (res_idx),
      .res_data   (res_data)
   );

   adc_seq_results #(
      .DW (RES_W)
   ) u_res (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (store_en),
      .wr_idx  (cur_idx),
      .wr_data (store_data),
      .rd_idx  (rd_idx),
      .rd_data (rd_data)
   );

   assign mux_sel  = cur_idx;
   assign first_rb = cfg_q.first;
   assign last_rb  = cfg_q.last;
   assign loop_rb  = cfg_q.loop_en;
   assign range_rb = cfg_q.range_hi;

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk
   import adc_seq_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             supply_hi,
   input logic             trig_bit,
   input logic             busy,
   input logic [IDX_W-1:0] mux_sel,
   input logic             conv_start,
   input logic             res_valid,
   input logic [IDX_W-1:0] first_rb,
   input logic [IDX_W-1:0] last_rb,
   input logic             loop_rb,
   input logic             range_rb
);

   // R3
   start_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> busy);

   // R3
   mux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !conv_start) |-> $stable(mux_sel));

   // R6
   trig_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig_bit |-> busy);

   // R4
   window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (mux_sel <= last_rb));

   // R7
   result_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   // R9
   range_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(range_rb) |-> $past(supply_hi));

   // R10
   cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(first_rb) && $stable(last_rb) && $stable(loop_rb) && $stable(range_rb)));

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (.*);

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;

   // 125 MHz: period 8 time units
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [3:0]  cfg_first = '0;
   logic [3:0]  cfg_last = '0;
   logic        cfg_loop = 1'b0;
   logic        cfg_range_hi = 1'b0;
   logic        cfg_ext1_en = 1'b1;
   logic [1:0]  cfg_rate_ext0 = '0;
   logic [1:0]  cfg_rate_ext1 = '0;
   logic        supply_hi = 1'b0;
   logic        trig_wr = 1'b0;
   logic        trig_val = 1'b0;
   logic        conv_done = 1'b0;
   logic [11:0] conv_data = '0;
   logic [3:0]  rd_idx = '0;
   logic        trig_bit, busy, conv_start, res_valid, loop_rb, range_rb;
   logic [3:0]  mux_sel, res_idx, first_rb, last_rb;
   logic [11:0] res_data, rd_data;

   always #4 clk = ~clk;

   adc_seq_ctrl u0 (.*);

   int tests = 0;
   int fails = 0;
   longint cyc = 0;

   task automatic chk(input string tag, input string what, input longint act, input longint exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", tag, what, act, exp, cyc);
      end
   endtask

   // ---------------- reference model ----------------
   int m_first, m_last, m_loop, m_range, m_en1, m_rate0, m_rate1;
   int m_busy, m_trig, m_cur, m_cyc, m_lat, m_cs, m_rv, m_ridx, m_rdata;
   int m_res [16];

   function automatic int slot_ticks(input int idx);
      if (idx == 1) return 20 + 4 * m_rate0;
      if (idx == 2) return 20 + 4 * m_rate1;
      return 20;
   endfunction

   task automatic model_reset();
      m_first = 0; m_last = 8; m_loop = 0; m_range = 0; m_en1 = 1;
      m_rate0 = 0; m_rate1 = 0;
      m_busy = 0; m_trig = 0; m_cur = 0; m_cyc = 0; m_lat = 0;
      m_cs = 0; m_rv = 0; m_ridx = 0; m_rdata = 0;
      for (int i = 0; i < 16; i++) m_res[i] = 0;
   endtask

   task automatic model_launch(input int idx);
      m_cur = idx; m_cyc = 0; m_lat = 0; m_cs = 1; m_busy = 1;
   endtask

   task automatic model_step();
      int lo;
      int was_busy;
      int was_trig;
      bit done_now;
      lo = (m_first > m_last) ? m_last : m_first;
      was_busy = m_busy;
      was_trig = m_trig;
      m_cs = 0;
      m_rv = 0;
      done_now = 0;
      if (m_busy != 0) begin
         m_cyc++;
         if (m_cyc == 16 * slot_ticks(m_cur)) done_now = 1;
      end
      if (done_now) begin
         m_rdata = (m_cur == 2 && m_en1 == 0) ? 0 : m_lat;
         m_res[m_cur] = m_rdata;
         m_ridx = m_cur;
         m_rv = 1;
      end
      if (m_busy != 0 && conv_done) m_lat = conv_data;
      if (done_now) begin
         if (was_trig == 0) m_busy = 0;
         else if (m_cur == m_last) begin
            if (m_loop != 0) model_launch(lo);
            else begin m_busy = 0; m_trig = 0; end
         end else model_launch(m_cur + 1);
      end
      if (trig_wr) begin
         if (!trig_val) m_trig = 0;
         else if (was_busy == 0) begin m_trig = 1; model_launch(lo); end
      end
      if (cfg_wr && was_busy == 0) begin
         m_first = cfg_first; m_last = cfg_last; m_loop = cfg_loop;
         m_range = cfg_range_hi & supply_hi; m_en1 = cfg_ext1_en;
         m_rate0 = cfg_rate_ext0; m_rate1 = cfg_rate_ext1;
      end
   endtask

   task automatic compare();
      chk("R11", "busy", busy, m_busy);
      chk("R3", "trig_bit", trig_bit, m_trig);
      chk("R3", "mux_sel", mux_sel, m_cur);
      chk("R3", "conv_start", conv_start, m_cs);
      chk("R7", "res_valid", res_valid, m_rv);
      if (m_rv != 0) begin
         chk("R7", "res_idx", res_idx, m_ridx);
         chk("R7", "res_data", res_data, m_rdata);
      end
      chk("R7", "rd_data", rd_data, m_res[rd_idx]);
      chk("R10", "first_rb", first_rb, m_first);
      chk("R10", "last_rb", last_rb, m_last);
      chk("R10", "loop_rb", loop_rb, m_loop);
      chk("R9", "range_rb", range_rb, m_range);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) model_reset();
      else model_step();
      #2;
      if (rst_n) compare();
   end

   // ---------------- strobe monitor ----------------
   int     obs_idx [$];
   longint obs_t [$];

   always @(posedge clk) begin
      #2;
      if (rst_n && conv_start) begin
         obs_idx.push_back(int'(mux_sel));
         obs_t.push_back(cyc);
      end
   end

   // ---------------- converter model ----------------
   int       core_cnt = 0;
   bit       core_mute = 0;
   bit [7:0] core_seq = 8'h11;

   always @(negedge clk) begin
      if (conv_start) core_cnt = 5;
      else if (core_cnt > 0) core_cnt--;
      conv_done = (core_cnt == 1) && !core_mute;
      if (conv_done) begin
         conv_data = {mux_sel, core_seq};
         core_seq = core_seq + 8'd7;
      end
   end

   bit sweep = 1;
   always @(negedge clk) if (sweep) rd_idx <= rd_idx + 1'b1;

   // ---------------- stimulus helpers ----------------
   task automatic write_cfg(input int f, input int l, input bit lp, input bit rh,
                            input bit e1, input int r0, input int r1);
      @(negedge clk);
      cfg_first = 4'(f); cfg_last = 4'(l); cfg_loop = lp; cfg_range_hi = rh;
      cfg_ext1_en = e1; cfg_rate_ext0 = 2'(r0); cfg_rate_ext1 = 2'(r1);
      cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic write_trig(input bit v);
      @(negedge clk);
      trig_val = v; trig_wr = 1'b1;
      @(negedge clk);
      trig_wr = 1'b0;
   endtask

   task automatic wait_idle();
      int n = 0;
      while (busy && n < 30000) begin
         @(negedge clk);
         n++;
      end
      chk("R11", "sequence ends", busy, 0);
      repeat (3) @(negedge clk);
   endtask

   task automatic clear_obs();
      obs_idx.delete();
      obs_t.delete();
   endtask

   task automatic check_order(input int lo, input int hi, input int exact, input string tag);
      int span = hi - lo + 1;
      if (exact >= 0) chk(tag, "strobe count", obs_idx.size(), exact);
      foreach (obs_idx[i]) chk(tag, "slot order", obs_idx[i], lo + (i % span));
   endtask

   task automatic peek_result(input int idx, input int exp, input string tag);
      sweep = 0;
      @(negedge clk);
      rd_idx = 4'(idx);
      @(negedge clk);
      chk(tag, "stored result", rd_data, exp);
      sweep = 1;
   endtask

   task automatic report();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      report();
   end

   // ---------------- scenarios ----------------
   initial begin
      int n_at_stop;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "busy", busy, 0);
      chk("R1", "trig_bit", trig_bit, 0);
      chk("R1", "first_rb", first_rb, 0);
      chk("R1", "last_rb", last_rb, 8);
      chk("R1", "loop_rb", loop_rb, 0);
      chk("R1", "range_rb", range_rb, 0);
      chk("R1", "mux_sel", mux_sel, 0);
      chk("R1", "rd_data", rd_data, 0);

      // default window, one-shot
      clear_obs();
      write_trig(1);
      wait_idle();
      check_order(0, 8, 9, "R3");
      if (obs_t.size() >= 5) chk("R2", "fixed slot length", obs_t[4] - obs_t[3], 320);

      // narrower window
      write_cfg(3, 5, 0, 0, 1, 0, 0);
      clear_obs();
      write_trig(1);
      wait_idle();
      check_order(3, 5, 3, "R3");

      // programmed rates on the external inputs
      write_cfg(1, 2, 0, 0, 1, 2, 3);
      clear_obs();
      write_trig(1);
      wait_idle();
      check_order(1, 2, 2, "R2");
      if (obs_t.size() >= 2) chk("R2", "ext0 slot length", obs_t[1] - obs_t[0], 448);

      // first above last
      write_cfg(7, 4, 0, 0, 1, 0, 0);
      clear_obs();
      write_trig(1);
      wait_idle();
      check_order(4, 4, 1, "R4");

      // first equals last
      write_cfg(6, 6, 0, 0, 1, 0, 0);
      clear_obs();
      write_trig(1);
      wait_idle();
      check_order(6, 6, 1, "R4");

      // external input 1 disabled
      write_cfg(1, 3, 0, 0, 0, 0, 1);
      clear_obs();
      write_trig(1);
      wait_idle();
      check_order(1, 3, 3, "R8");
      if (obs_t.size() >= 3) chk("R8", "disabled slot length", obs_t[2] - obs_t[1], 384);
      peek_result(2, 0, "R8");

      // range bit gating
      supply_hi = 1'b0;
      write_cfg(0, 8, 0, 1, 1, 0, 0);
      @(negedge clk);
      chk("R9", "range with supply low", range_rb, 0);
      supply_hi = 1'b1;
      write_cfg(0, 8, 0, 1, 1, 0, 0);
      @(negedge clk);
      chk("R9", "range with supply high", range_rb, 1);

      // looping mode, writes while busy, then stop request
      write_cfg(2, 4, 1, 0, 1, 0, 0);
      clear_obs();
      write_trig(1);
      repeat (1000) @(negedge clk);
      write_cfg(0, 1, 0, 0, 1, 0, 0);
      @(negedge clk);
      chk("R10", "first frozen while busy", first_rb, 2);
      chk("R10", "loop frozen while busy", loop_rb, 1);
      write_trig(1);
      repeat (1600) @(negedge clk);
      write_trig(0);
      chk("R6", "trig cleared", trig_bit, 0);
      chk("R6", "still busy after stop request", busy, 1);
      n_at_stop = obs_idx.size();
      wait_idle();
      chk("R6", "no strobe after stop request", obs_idx.size(), n_at_stop);
      check_order(2, 4, -1, "R5");
      chk("R5", "wrapped at least twice", obs_idx.size() > 6, 1);

      // stop request in one-shot mode
      write_cfg(0, 8, 0, 0, 1, 0, 0);
      clear_obs();
      write_trig(1);
      repeat (500) @(negedge clk);
      write_trig(0);
      wait_idle();
      check_order(0, 8, 2, "R6");

      // missing conversion-done gives zero
      write_cfg(9, 9, 0, 0, 1, 0, 0);
      write_trig(1);
      wait_idle();
      peek_result(9, 12'h900 | 12'(core_seq - 8'd7), "R7");
      core_mute = 1;
      write_trig(1);
      wait_idle();
      peek_result(9, 0, "R7");
      core_mute = 0;

      repeat (5) @(negedge clk);
      report();
   end

endmodule